// File: doc/BRIEF.md
# Fractional Clock Divider

This block derives a slower module clock from a fast source clock by producing one enable pulse per output period. The average output period is an integer number of source cycles N plus a fraction b/a. To reach the fraction, the block mixes long periods of N+1 cycles with short periods of N cycles. Over each run of a output periods, exactly b of them are long.

The fraction is first turned into a compact spacing code: a base spacing x, a remainder count y, a group count z and a polarity flag. The flag tells whether the spaced-out periods are the long ones or the short ones. When b is more than half of a, the code is mirrored onto a−b. The sparse periods are then always the minority kind, and they never sit next to each other.

A sequencer walks through z groups per window. Each group holds x or x+1 majority periods and ends with one minority period. The block also drives a clock-like output that is high for the first half of every period. New settings are taken only when a window ends, so a period is never cut short or stretched by a setting change.

Top module: `frac_clk_div`

## Requirements
- R1: Counted from the start of operation, every window of `frac_den` consecutive output periods lasts exactly N·`frac_den` + `frac_num` source cycles and contains exactly `frac_num` long periods, where N is the effective integer divisor.
- R2: Every output period lasts either N or N+1 source cycles.
- R3: If `frac_den` is 0, or `frac_num` is 0, or `frac_num` ≥ `frac_den`, every period lasts exactly N cycles.
- R4: The effective divisor N equals `div_int`, except that values 0 and 1 are treated as 2.
- R5: `div_int` is 9 bits wide, and the largest setting, 511, gives periods of 511 and 512 cycles.
- R6: Changes to `div_int`, `frac_den` or `frac_num` take effect only after the current window of `frac_den` periods completes (after the current period when no fraction is active).
- R7: `tick` is high for exactly one source cycle, the last cycle of each period. `clk_out` is high for the first floor(L/2) cycles of a period of length L and low for the rest.
- R8: While `en` is low, `tick` and `clk_out` stay low. When `en` is raised again, a fresh window starts one cycle later with the current settings.
- R9: While `rst` is high, `tick` and `clk_out` are low.
- R10: The minority periods are never adjacent. The minority is the long kind when `frac_num` ≤ floor(`frac_den`/2), and the short kind otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the divider idle |
| div_int | input | 9 | Integer divisor N |
| frac_den | input | 6 | Fraction denominator a |
| frac_num | input | 6 | Fraction numerator b |
| tick | output | 1 | One-cycle pulse on the last cycle of each period |
| clk_out | output | 1 | Roughly half-duty divided clock |

## Verification
The divider is run with fractions at or below one half (long periods are sparse), with fractions above one half (the mirrored code, where short periods are sparse), and with a fraction of exactly one half. Runs near the limits cover a 15/16 ratio, the largest divisor, and a divisor clamped up to 2. Settings that should collapse to a pure integer divide are also applied: a zero numerator, a zero denominator, and a numerator at or above the denominator. For each run, the bench separates a correct total per window from a correct mix of long and short periods and from correct spacing of the minority periods. A setting change issued mid-window shows whether the new values are deferred to the window edge. An enable drop shows whether the outputs go quiet and whether the sequence restarts cleanly.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    parameter int unsigned INT_W  = 9;
    parameter int unsigned FRAC_W = 6;
    localparam int unsigned CNT_W = INT_W + 1;
    localparam logic [FRAC_W-1:0] F_ONE = FRAC_W'(1);

    // Spacing code for one window of output periods
    typedef struct packed {
        logic [INT_W-1:0]  base;    // effective integer divisor
        logic [FRAC_W-1:0] x;       // majority periods per group, minus the extra
        logic [FRAC_W-1:0] y;       // remainder code
        logic [FRAC_W-1:0] z;       // number of groups (minority periods)
        logic              mirror;  // minority periods are the short ones
        logic              frac_on; // fraction active
    } cfg_t;

    function automatic logic [INT_W-1:0] clamp_base(input logic [INT_W-1:0] n);
        return (n < INT_W'(2)) ? INT_W'(2) : n;
    endfunction
endpackage

// File: rtl/fdiv_param_calc.sv
module fdiv_param_calc
    import fdiv_pkg::*;
(
    input  logic [INT_W-1:0]  n_in,
    input  logic [FRAC_W-1:0] den,
    input  logic [FRAC_W-1:0] num,
    output cfg_t              cfg
);
    logic [FRAC_W-1:0] diff;

    assign diff = den - num;

    always_comb begin
        cfg         = '0;
        cfg.base    = clamp_base(n_in);
        cfg.frac_on = (den != '0) && (num != '0) && (num < den);
        if (cfg.frac_on) begin
            if (num > (den >> 1)) begin
                cfg.mirror = 1'b1;
                cfg.z      = diff;
                cfg.x      = (den / diff) - F_ONE;
                cfg.y      = den % diff;
            end else begin
                cfg.mirror = 1'b0;
                cfg.z      = num;
                cfg.x      = (den / num) - F_ONE;
                cfg.y      = (den % num) + F_ONE;
            end
        end
    end
endmodule

// File: rtl/fdiv_period_seq.sv
module fdiv_period_seq
    import fdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  cfg_t nxt_cfg,
    output logic tick,
    output logic clk_out
);
    cfg_t              cur;
    logic              run;
    logic [CNT_W-1:0]  cyc;
    logic [FRAC_W-1:0] grp;
    logic [FRAC_W-1:0] sub;

    logic [FRAC_W-1:0] extras;
    logic [FRAC_W-1:0] need;
    logic              minor;
    logic              long_p;
    logic [CNT_W-1:0]  len;
    logic              last;

    always_comb begin
        extras = cur.mirror ? cur.y : (cur.y - F_ONE);
        need   = cur.x + ((grp < extras) ? F_ONE : '0);
        minor  = cur.frac_on && (sub == need);
        long_p = cur.frac_on && (minor ^ cur.mirror);
        len    = {1'b0, cur.base} + CNT_W'(long_p);
        last   = run && (cyc == (len - CNT_W'(1)));
    end

    assign tick    = last;
    assign clk_out = run && (cyc < (len >> 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run <= 1'b0;
            cur <= '0;
            cyc <= '0;
            grp <= '0;
            sub <= '0;
        end else if (!run) begin
            run <= 1'b1;
            cur <= nxt_cfg;
            cyc <= '0;
            grp <= '0;
            sub <= '0;
        end else if (last) begin
            cyc <= '0;
            if (!cur.frac_on) begin
                cur <= nxt_cfg;
            end else if (minor) begin
                sub <= '0;
                if (grp == (cur.z - F_ONE)) begin
                    grp <= '0;
                    cur <= nxt_cfg;
                end else begin
                    grp <= grp + F_ONE;
                end
            end else begin
                sub <= sub + F_ONE;
            end
        end else begin
            cyc <= cyc + CNT_W'(1);
        end
    end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import fdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] frac_den,
    input  logic [FRAC_W-1:0] frac_num,
    output logic              tick,
    output logic              clk_out
);
    cfg_t calc_cfg;

    fdiv_param_calc u_calc (
        .n_in (div_int),
        .den  (frac_den),
        .num  (frac_num),
        .cfg  (calc_cfg)
    );

    fdiv_period_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .nxt_cfg (calc_cfg),
        .tick    (tick),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker
    import fdiv_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic en,
    input logic tick,
    input logic clk_out
);
    localparam int MAX_LEN = 1 << INT_W;

    logic [CNT_W:0] gap;
    logic           seen;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (tick) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    // R2: a full period between ticks lasts 2..2^INT_W cycles
    a_r2_period_bounds: assert property (@(posedge clk) disable iff (rst)
        (tick && seen) |-> (int'(gap) >= 1 && int'(gap) <= MAX_LEN - 1));

    // R7: tick lasts a single cycle
    a_r7_single_tick: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R7: the last cycle of a period is in the low half
    a_r7_low_at_end: assert property (@(posedge clk) disable iff (rst)
        tick |-> !clk_out);

    // R8: disabled divider stays quiet
    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!tick && !clk_out));

    // R9: reset holds outputs low
    a_r9_reset_quiet: assert property (@(posedge clk)
        rst |=> (!tick && !clk_out));
endmodule

bind frac_clk_div fdiv_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .tick    (tick),
    .clk_out (clk_out)
);

// File: tb/test_frac_clk_div.sv
module test_frac_clk_div;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [8:0] div_int  = '0;
    logic [5:0] frac_den = '0;
    logic [5:0] frac_num = '0;
    logic       tick;
    logic       clk_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    frac_clk_div i_frac_clk_div (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .div_int  (div_int),
        .frac_den (frac_den),
        .frac_num (frac_num),
        .tick     (tick),
        .clk_out  (clk_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts one period: returns length and number of high clk_out cycles
    task automatic next_period(output int len, output int hi);
        len = 0;
        hi  = 0;
        do begin
            @(negedge clk);
            len++;
            if (clk_out) hi++;
        end while (!tick && len < 2000);
    endtask

    task automatic start(input int n, input int a, input int b);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        div_int  = 9'(n);
        frac_den = 6'(a);
        frac_num = 6'(b);
        en = 1'b1;
    endtask

    task automatic t_reset();
        en = 1'b1;
        div_int = 9'd4;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!tick && !clk_out, "R9 reset outputs", int'(tick) + int'(clk_out), 0);
        end
        en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_integer(input int n, input int a, input int b, input int exp_len);
        int len, hi;
        start(n, a, b);
        for (int i = 0; i < 6; i++) begin
            next_period(len, hi);
            chk(len == exp_len, "R3/R4 integer period", len, exp_len);
            chk(hi == exp_len / 2, "R7 clk_out high time", hi, exp_len / 2);
        end
    endtask

    task automatic t_frac(input int n, input int a, input int b, input int windows);
        int len, hi, sum, longs, nb;
        bit mirror, prev_min, cur_min;
        nb = (n < 2) ? 2 : n;
        mirror = (b > a / 2);
        prev_min = 1'b0;
        start(n, a, b);
        for (int w = 0; w < windows; w++) begin
            sum = 0;
            longs = 0;
            for (int p = 0; p < a; p++) begin
                next_period(len, hi);
                chk(len == nb || len == nb + 1, "R2 period length", len, nb);
                chk(hi == len / 2, "R7 clk_out high time", hi, len / 2);
                sum += len;
                if (len == nb + 1) longs++;
                cur_min = mirror ? (len == nb) : (len == nb + 1);
                chk(!(cur_min && prev_min), "R10 minority adjacency", len, nb);
                prev_min = cur_min;
            end
            chk(sum == a * nb + b, "R1 window total", sum, a * nb + b);
            chk(longs == b, "R1 long count", longs, b);
        end
    endtask

    task automatic t_change();
        int len, hi, sum;
        sum = 0;
        start(8, 5, 2);
        for (int p = 0; p < 2; p++) begin
            next_period(len, hi);
            sum += len;
        end
        div_int  = 9'd20;
        frac_den = 6'd0;
        frac_num = 6'd0;
        for (int p = 0; p < 3; p++) begin
            next_period(len, hi);
            chk(len == 8 || len == 9, "R6 old settings held", len, 8);
            sum += len;
        end
        chk(sum == 42, "R6 window total before change", sum, 42);
        next_period(len, hi);
        chk(len == 20, "R6 new settings after window", len, 20);
    endtask

    task automatic t_disable();
        int len, hi, bad;
        start(6, 0, 0);
        next_period(len, hi);
        @(negedge clk);
        en = 1'b0;
        div_int = 9'd7;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick || clk_out) bad++;
        end
        chk(bad == 0, "R8 quiet while disabled", bad, 0);
        en = 1'b1;
        next_period(len, hi);
        chk(len == 7, "R8 fresh start after enable", len, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_integer(5, 0, 3, 5);    // R3 zero denominator
        t_integer(7, 4, 0, 7);    // R3 zero numerator
        t_integer(6, 3, 3, 6);    // R3 num equal to den
        t_integer(6, 3, 5, 6);    // R3 num above den
        t_integer(0, 0, 0, 2);    // R4 clamp
        t_integer(1, 0, 0, 2);    // R4 clamp
        t_frac(10, 7, 2, 3);      // R10 long minority
        t_frac(10, 7, 5, 3);      // R10 mirrored, short minority
        t_frac(10, 7, 3, 2);
        t_frac(4, 8, 4, 2);       // exactly half
        t_frac(3, 16, 15, 2);
        t_frac(2, 5, 1, 2);
        t_frac(0, 4, 1, 2);       // R4 clamp with fraction
        t_frac(511, 3, 1, 2);     // R5 largest divisor
        t_frac(5, 63, 31, 1);
        t_change();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule